// File: doc/BRIEF.md
# Synchronous Burst Memory Clock and Latency Unit

This unit runs one synchronous burst at a time against an external NOR flash or a cellular PSRAM. It makes a memory clock by dividing the system clock. It drives chip select, an address-valid strobe and a write strobe. It counts the first-data latency and then moves one beat per memory clock. The memory's wait input can hold off any beat.

A request carries a start byte address, a beat count and a direction. The request is taken with a valid/ready handshake. Configuration is applied per request and has these parts:

- the divide ratio
- the latency
- the memory kind (NOR or PSRAM)
- a page size
- the wait polarity and wait timing
- whether the clock runs continuously
- whether write bursts are allowed

For PSRAM with a page size set, a burst that reaches a page boundary is closed. It then restarts with a fresh address phase at the new page.

The unit updates state once per memory clock period, in the last system cycle of the period (the tick). That cycle is the low half of the memory clock, just before its next rising edge. Every memory clock period therefore carries exactly one of these:

- an address phase
- a latency or stall period
- a beat
- a gap with chip select high

Top module: `sbm_burst`

## Requirements
- R1: After reset, and whenever no burst is in progress, `mem_cs_n` and `mem_adv_n` are 1, `beat` is 0 and `req_ready` is 1 when the clock is gated.
- R2: The memory clock period is `cfg_clk_div` system cycles (clamped to 2..16). The clock is high for the first floor(D/2) cycles of each period. Each `beat` pulse falls in the last cycle of a period, while the clock is low.
- R3: With `cfg_clk_cont`=0 the memory clock is held low while idle, and a request is accepted at once. With `cfg_clk_cont`=1 the clock toggles while idle, and a request is accepted only in the last cycle of a period.
- R4: For NOR (`cfg_psram`=0), each segment is one address period followed by L-1 latency periods, where L is `cfg_latency` clamped to 2..17. The first beat can occur in period L counted from the address period.
- R5: For PSRAM (`cfg_psram`=1), `cfg_latency` is ignored. Data periods follow the address period directly, and only the wait input holds off the first beat.
- R6: Wait is active when `mem_wait` equals `cfg_wait_pol`. With `cfg_wait_early`=0, wait seen in a data period stalls that period. With `cfg_wait_early`=1, wait seen in the previous period stalls it. A stalled period produces no beat, and the memory clock keeps its period.
- R7: For PSRAM, `cfg_page_sel` values 1, 2, 3 and 4 select pages of 128, 256, 512 and 1024 bytes; other values disable splitting. When a beat leaves the next address on a page boundary and beats remain, chip select goes high for exactly one memory clock period. A new address phase then starts at that address.
- R8: For a write (`req_write`=1) with `cfg_wr_burst`=0, every beat is its own segment: address phase, latency, one beat, then a one-period gap. `mem_we_n` is low while chip select is low during a write, and high during a read.
- R9: A burst produces exactly `req_beats` beats (0 counts as 1). `beat_last` marks the final one. The address advances by DW/8 bytes after every beat, starting from `req_addr` aligned down to DW/8.
- R10: `mem_adv_n` is low for exactly the first period of every segment and only while chip select is low. `mem_addr` then shows the segment's start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_clk_div | input | 5 | Memory clock period in system cycles |
| cfg_latency | input | 5 | NOR first-data latency in memory clocks |
| cfg_psram | input | 1 | 1 selects PSRAM behaviour, 0 NOR |
| cfg_page_sel | input | 3 | PSRAM page size select, 0 = no split |
| cfg_wait_pol | input | 1 | Level of `mem_wait` that means wait |
| cfg_wait_early | input | 1 | 1 = wait applies one period later |
| cfg_clk_cont | input | 1 | 1 = memory clock runs while idle |
| cfg_wr_burst | input | 1 | 1 = writes may burst |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | AW | Start byte address |
| req_beats | input | BW | Number of beats |
| req_write | input | 1 | 1 = write burst |
| mem_clk | output | 1 | Divided memory clock |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Current byte address |
| mem_wait | input | 1 | Wait from the memory |
| beat | output | 1 | One-cycle pulse per transferred beat |
| beat_last | output | 1 | Marks the final beat of the burst |

## Verification
The checker watches the following on every cycle:

- the address strobe stays inside chip select, and every fall of chip select opens with an address phase
- beats land in the clock's low half, and the address steps by one beat width after each beat
- `beat_last` only accompanies a beat
- a gated clock stays low while idle

The bench covers what only whole scenarios show. It records each burst as a per-period trace of address, latency or stall, beat and gap periods. That trace covers NOR latency counts, PSRAM wait-paced starts, both wait timings and polarities, page-boundary splits and single-transfer writes. The bench compares the trace, the segment addresses and the period lengths against a period-level model.

// File: rtl/sbm_burst.sv
module sbm_burst #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    cfg_clk_div,
  input  logic [4:0]    cfg_latency,
  input  logic          cfg_psram,
  input  logic [2:0]    cfg_page_sel,
  input  logic          cfg_wait_pol,
  input  logic          cfg_wait_early,
  input  logic          cfg_clk_cont,
  input  logic          cfg_wr_burst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_beats,
  input  logic          req_write,
  output logic          mem_clk,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_wait,
  output logic          beat,
  output logic          beat_last
);
  localparam int BPB = DW / 8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LAT, S_DATA, S_GAP} st_t;

  st_t           st;
  logic [3:0]    ph;
  logic [4:0]    lat_cnt;
  logic [BW-1:0] rem;
  logic [AW-1:0] cur_addr;
  logic          wr_q, wait_q;

  logic [4:0]    div, lat_l;
  logic [10:0]   pmask;
  logic [AW-1:0] next_addr;
  logic          run, tick, wait_now, stall, split_hit, seg_end, accept;

  assign div   = (cfg_clk_div < 5'd2) ? 5'd2 : (cfg_clk_div > 5'd16) ? 5'd16 : cfg_clk_div;
  assign lat_l = (cfg_latency < 5'd2) ? 5'd2 : (cfg_latency > 5'd17) ? 5'd17 : cfg_latency;
  assign run   = cfg_clk_cont | (st != S_IDLE);
  assign tick  = ({1'b0, ph} >= div - 5'd1);
  assign mem_clk = run & ({1'b0, ph} < (div >> 1));

  assign wait_now = (mem_wait == cfg_wait_pol);
  assign stall    = cfg_wait_early ? wait_q : wait_now;
  assign beat      = (st == S_DATA) & tick & ~stall;
  assign beat_last = beat & (rem == BW'(1));

  always_comb begin
    case (cfg_page_sel)
      3'd1:    pmask = 11'd127;
      3'd2:    pmask = 11'd255;
      3'd3:    pmask = 11'd511;
      3'd4:    pmask = 11'd1023;
      default: pmask = 11'd0;
    endcase
  end

  assign next_addr = cur_addr + AW'(BPB);
  assign split_hit = cfg_psram & (pmask != 11'd0) & ((next_addr[10:0] & pmask) == 11'd0);
  assign seg_end   = (wr_q & ~cfg_wr_burst) | split_hit;

  assign req_ready = (st == S_IDLE) & (~cfg_clk_cont | tick);
  assign accept    = req_valid & req_ready;

  assign mem_cs_n  = (st == S_IDLE) | (st == S_GAP);
  assign mem_adv_n = (st != S_ADDR);
  assign mem_we_n  = ~(wr_q & ~mem_cs_n);
  assign mem_addr  = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!run || tick) begin
      ph <= '0;
    end else begin
      ph <= ph + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
    end else if (st == S_IDLE) begin
      wait_q <= 1'b0;
    end else if (tick) begin
      wait_q <= wait_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lat_cnt  <= '0;
      rem      <= '0;
      cur_addr <= '0;
      wr_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_ADDR;
          cur_addr <= req_addr & ~AW'(BPB - 1);
          rem      <= (req_beats == '0) ? BW'(1) : req_beats;
          wr_q     <= req_write;
        end
        S_ADDR: if (tick) begin
          if (cfg_psram) begin
            st <= S_DATA;
          end else begin
            st      <= S_LAT;
            lat_cnt <= lat_l - 5'd1;
          end
        end
        S_LAT: if (tick) begin
          if (lat_cnt == 5'd1) st <= S_DATA;
          lat_cnt <= lat_cnt - 5'd1;
        end
        S_DATA: if (beat) begin
          rem      <= rem - BW'(1);
          cur_addr <= next_addr;
          if (rem == BW'(1)) begin
            st   <= S_IDLE;
            wr_q <= 1'b0;
          end else if (seg_end) begin
            st <= S_GAP;
          end
        end
        S_GAP: if (tick) st <= S_ADDR;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sbm_burst_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_clk_cont,
  input logic          req_ready,
  input logic          mem_clk,
  input logic          mem_cs_n,
  input logic          mem_adv_n,
  input logic [AW-1:0] mem_addr,
  input logic          beat,
  input logic          beat_last
);
  localparam int BPB = DW / 8;

  assert_adv_in_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_cs_n);

  assert_seg_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> !mem_adv_n);

  assert_last_is_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat);

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (mem_addr == $past(mem_addr) + AW'(BPB)));

  assert_beat_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> !mem_clk);

  assert_gated_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !cfg_clk_cont) |-> (!mem_clk && mem_cs_n));
endmodule

bind sbm_burst sbm_burst_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_clk_cont(cfg_clk_cont), .req_ready(req_ready),
  .mem_clk(mem_clk), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
  .mem_addr(mem_addr), .beat(beat), .beat_last(beat_last)
);

// File: tb/sbm_burst_bench.sv
`timescale 1ns/1ps
module sbm_burst_bench;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] cfg_clk_div = 5'd4;
  logic [4:0] cfg_latency = 5'd2;
  logic cfg_psram = 0, cfg_wait_pol = 1, cfg_wait_early = 0, cfg_clk_cont = 0, cfg_wr_burst = 1;
  logic [2:0] cfg_page_sel = 3'd0;
  logic req_valid = 0, req_write = 0, mem_wait = 0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_beats = '0;
  logic req_ready, mem_clk, mem_cs_n, mem_adv_n, mem_we_n, beat, beat_last;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  sbm_burst #(.AW(AW), .DW(DW), .BW(BW)) u_sbm_burst (
    .clk(clk), .rst_n(rst_n), .cfg_clk_div(cfg_clk_div), .cfg_latency(cfg_latency),
    .cfg_psram(cfg_psram), .cfg_page_sel(cfg_page_sel), .cfg_wait_pol(cfg_wait_pol),
    .cfg_wait_early(cfg_wait_early), .cfg_clk_cont(cfg_clk_cont), .cfg_wr_burst(cfg_wr_burst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
    .req_write(req_write), .mem_clk(mem_clk), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wait(mem_wait), .beat(beat),
    .beat_last(beat_last)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  byte exp_code[1024];
  byte got_code[1024];
  int  exp_n, got_n, exp_na, got_na;
  logic [AW-1:0] exp_adr[256];
  logic [AW-1:0] got_adr[256];
  bit  wpat[1024];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic bit page_edge(input int a);
    int sz;
    if (!cfg_psram || cfg_page_sel == 0 || cfg_page_sel > 4) return 0;
    sz = 64 << cfg_page_sel;
    return (a % sz) == 0;
  endfunction

  // Period-level model of R4..R10
  task automatic build_expected(input int start, input int beats, input bit wr);
    int p = 0, addr = start & ~1, rem = (beats == 0) ? 1 : beats;
    int lat = (cfg_latency < 2) ? 2 : (cfg_latency > 17) ? 17 : int'(cfg_latency);
    bit done = 0;
    exp_na = 0;
    while (!done) begin
      exp_code[p] = "A"; exp_adr[exp_na] = AW'(addr); exp_na++; p++;
      if (!cfg_psram) for (int i = 0; i < lat - 1; i++) begin exp_code[p] = "w"; p++; end
      while (1) begin
        bit stl = cfg_wait_early ? wpat[p-1] : wpat[p];
        if (stl) begin exp_code[p] = "w"; p++; continue; end
        exp_code[p] = "B"; p++; rem--; addr += DW/8;
        if (rem == 0) begin done = 1; break; end
        if ((wr && !cfg_wr_burst) || page_edge(addr)) begin exp_code[p] = "G"; p++; break; end
      end
    end
    exp_n = p;
  endtask

  task automatic run_burst(input int start, input int beats, input bit wr, input int wprob);
    int p = -1, cyc = 0, guard = 0, len_bad = 0, we_bad = 0, nb = 0, rises = 0;
    int d = (cfg_clk_div < 2) ? 2 : (cfg_clk_div > 16) ? 16 : int'(cfg_clk_div);
    bit prev = 0, done = 0, csl = 0, av = 0, bt = 0, same = 1;
    string se = "", sg = "";
    for (int i = 0; i < 1024; i++) wpat[i] = (($urandom % 100) < wprob);
    build_expected(start, beats, wr);
    got_na = 0;
    @(negedge clk);
    req_addr = AW'(start); req_beats = BW'(beats); req_write = wr; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    while (!done && guard < 20000) begin
      @(negedge clk); guard++;
      if (mem_clk && !prev) begin
        if (p >= 0) begin
          got_code[p] = bt ? "B" : av ? "A" : csl ? "w" : "G";
          if (cyc != d) len_bad++;
        end
        p++; cyc = 0; csl = 0; av = 0; bt = 0;
        mem_wait = wpat[p] ~^ cfg_wait_pol;
      end
      cyc++; prev = mem_clk;
      if (!mem_cs_n) begin csl = 1; if (mem_we_n != !wr) we_bad++; end
      if (!mem_adv_n && !av) begin av = 1; got_adr[got_na] = mem_addr; got_na++; end
      if (beat) begin bt = 1; nb++; end
      if (beat_last) begin got_code[p] = "B"; done = 1; end
    end
    mem_wait = ~cfg_wait_pol;
    got_n = p + 1;
    check(done, "R9", "burst completed (watchdog)", done, 1);
    if (got_n != exp_n) same = 0;
    for (int i = 0; i < exp_n && i < got_n; i++) if (got_code[i] != exp_code[i]) same = 0;
    for (int i = 0; i < exp_n; i++) se = $sformatf("%s%c", se, exp_code[i]);
    for (int i = 0; i < got_n; i++) sg = $sformatf("%s%c", sg, got_code[i]);
    if (!same) $display("FAIL R4 R5 R6 R7 R8 period trace: actual %s expected %s", sg, se);
    n_chk++; if (!same) n_fail++;
    check(nb == ((beats == 0) ? 1 : beats), "R9", "beat count", nb, (beats == 0) ? 1 : beats);
    check(got_na == exp_na, "R10", "segment count", got_na, exp_na);
    for (int i = 0; i < exp_na && i < got_na; i++)
      check(got_adr[i] == exp_adr[i], "R10", "segment address", got_adr[i], exp_adr[i]);
    check(len_bad == 0, "R2", "periods of wrong length", len_bad, 0);
    check(we_bad == 0, "R8", "write strobe mismatches", we_bad, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4 * d; i++) begin
      @(negedge clk);
      if (mem_clk && !prev) rises++;
      prev = mem_clk;
    end
    if (cfg_clk_cont) check(rises >= 1 && mem_cs_n, "R3", "idle clock rises (continuous)", rises, 1);
    else check(rises == 0 && mem_cs_n && req_ready, "R3", "idle clock rises (gated)", rises, 0);
  endtask

  task automatic set_cfg(input int d, input bit ps, input int lat, input int pg, input bit pol,
                         input bit early, input bit cont, input bit wrb);
    @(negedge clk); cfg_clk_cont = 0;
    repeat (2) @(negedge clk);
    cfg_clk_div = 5'(d); cfg_psram = ps; cfg_latency = 5'(lat); cfg_page_sel = 3'(pg);
    cfg_wait_pol = pol; cfg_wait_early = early; cfg_wr_burst = wrb;
    mem_wait = ~pol;
    @(negedge clk); cfg_clk_cont = cont;
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (4) @(negedge clk);
    check(mem_cs_n && mem_adv_n && !mem_clk && !beat, "R1", "idle outputs in reset",
          {mem_cs_n, mem_adv_n, mem_clk, beat}, 4'b1100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_adv_n && !mem_clk && req_ready && !beat, "R1", "idle outputs after reset",
          {mem_cs_n, mem_adv_n, mem_clk, req_ready, beat}, 5'b11010);
    // R7: PSRAM split at 128-byte page: A B B G A B B B B
    set_cfg(4, 1, 0, 1, 1, 0, 0, 1);
    run_burst(32'h7C, 6, 0, 0);
    // R5: PSRAM first data paced by wait, latency ignored
    set_cfg(3, 1, 9, 0, 0, 0, 1, 1);
    run_burst(32'h200, 4, 0, 40);
    // R8: NOR single-transfer writes
    set_cfg(2, 0, 2, 0, 1, 0, 0, 0);
    run_burst(32'h10, 3, 1, 0);
    // R4 and R2: largest divider and latency
    set_cfg(16, 0, 17, 0, 1, 0, 0, 1);
    run_burst(32'h40, 2, 0, 0);
    // R6: early wait timing, active-low wait
    set_cfg(2, 0, 3, 0, 0, 1, 1, 1);
    run_burst(32'h100, 8, 0, 50);
    // R9: zero beat count counts as one
    set_cfg(5, 1, 0, 2, 1, 0, 0, 1);
    run_burst(32'h3FE, 0, 1, 0);
    for (int k = 0; k < 40; k++) begin
      set_cfg(2 + $urandom % 15, $urandom % 2, 2 + $urandom % 16, $urandom % 5, $urandom % 2,
              $urandom % 2, $urandom % 2, $urandom % 2);
      run_burst(256 * ($urandom % 8) + 256 - 2 * ($urandom % 10), 1 + $urandom % 12,
                $urandom % 2, $urandom % 40);
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule